// File: doc/BRIEF.md
# Timer Interrupt Vectoring Controller

This block collects the timeout pulses of four timer channels and turns them into a single interrupt request for the CPU. Each pulse is held in a pending flag, but only when two enables are both set for that channel. One enable is in the controller's own mask. The other is the interrupt-enable bit of the channel's own control word, which arrives on an input. A pending flag stays set until software clears it by writing a one to it. While the flag is set, further pulses from that channel add nothing.

When the CPU acknowledges the request, the block works out an 8-bit vector and registers it. It does not take the vector from a daisy chain. The vector is the programmed top bits, placed in bits 7:5, ORed with twice the fixed priority of the winning channel. Channels 0 to 3 have priorities 3 to 6. When several flags are pending, the lowest channel wins.

A separate mask lets any channel's timeout pulse go out as a DMA trigger request. This path ignores every interrupt setting.

Top module: `tmr_irq_vectorer`

## Requirements
- R1: After reset, every configuration field and every pending flag is 0, and `irq_req`, `dma_req` and `irq_vector` are all 0.
- R2: A pulse on `tmo_pulse[i]` sets `pending[i]` at the same clock edge only when enable-mask bit i and `chan_ie[i]` are both 1. If either is 0, the pulse leaves the flag unchanged.
- R3: Once `pending[i]` is set, it stays set through further pulses and acknowledges, until a clear write reaches it. A repeated pulse creates no second event.
- R4: A write to the status register clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 alone. When a clear and a latching pulse hit the same channel in the same cycle, the flag ends up set.
- R5: `irq_req` is 1 exactly when the vectoring enable is 1 and at least one pending flag has its enable-mask bit set.
- R6: When `irq_ack` is sampled high while `irq_req` is 1, `irq_vector` becomes, one cycle later, top bits × 32 + 2 × (c + 3), where c is the lowest channel whose flag is pending and enabled. For example, top bits 110 with channel 2 give 0xCA.
- R7: `dma_req[i]` is 1 in the cycle after a pulse on `tmo_pulse[i]` when DMA-mask bit i is set, whatever the interrupt settings. Otherwise it is 0.
- R8: `cfg_sel` selects the register: 0 is vector configuration (top bits in data 7:5, vectoring enable in data bit 0), 1 is the interrupt enable mask (data 3:0, bit 0 = channel 0), 2 is the status clear, and 3 is the DMA mask (data 3:0). A write to one register leaves the others unchanged.
- R9: An acknowledge does not clear any pending flag. An acknowledge with `irq_req` at 0 leaves `irq_vector` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 8 | Write data |
| tmo_pulse | input | 4 | One-cycle timeout pulses, one per channel |
| chan_ie | input | 4 | Per-channel control-word interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge from the CPU |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | 8 | Vector registered on acknowledge |
| pending | output | 4 | Pending flags |
| dma_req | output | 4 | DMA trigger requests |

## Verification
The assertions check, on every cycle, that each flag is set, held and cleared as the requirements say. They also check that no request appears while vectoring is off, that every registered vector has bit 0 at 0 and an offset between 6 and 12, that the vector holds between acknowledges, and that every DMA request has a pulse behind it. Only the bench's scenarios can show the rest: which channel wins when several flags are pending, the exact vector value for given top bits, a clear and a pulse landing in the same cycle, and the gating by each enable source. For these, a behavioural model is compared against the design on every clock.

// File: rtl/tiv_pkg.sv
package tiv_pkg;
  localparam int unsigned PRIO_BASE = 3;

  typedef enum logic [1:0] {
    SEL_VEC  = 2'd0,
    SEL_IE   = 2'd1,
    SEL_STAT = 2'd2,
    SEL_DMA  = 2'd3
  } cfg_sel_e;

  // vector = top bits in 7:5 OR (priority << 1); priority = channel + base
  function automatic logic [7:0] tiv_vector(input logic [2:0] top, input int unsigned ch);
    logic [7:0] off;
    off = 8'((ch + PRIO_BASE) << 1);
    return {top, 5'b00000} | off;
  endfunction
endpackage

// File: rtl/tiv_cfg.sv
module tiv_cfg import tiv_pkg::*; #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [1:0]     sel,
  input  logic [7:0]     wdata,
  output logic [2:0]     top,
  output logic           hw_en,
  output logic [NCH-1:0] ie,
  output logic [NCH-1:0] dmask,
  output logic [NCH-1:0] clr
);
  logic wr_vec, wr_ie, wr_dma;
  assign wr_vec = wr && (cfg_sel_e'(sel) == SEL_VEC);
  assign wr_ie  = wr && (cfg_sel_e'(sel) == SEL_IE);
  assign wr_dma = wr && (cfg_sel_e'(sel) == SEL_DMA);
  assign clr    = (wr && (cfg_sel_e'(sel) == SEL_STAT)) ? wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top   <= '0;
      hw_en <= 1'b0;
      ie    <= '0;
      dmask <= '0;
    end else begin
      if (wr_vec) begin
        top   <= wdata[7:5];
        hw_en <= wdata[0];
      end
      if (wr_ie)  ie    <= wdata[NCH-1:0];
      if (wr_dma) dmask <= wdata[NCH-1:0];
    end
  end

  a_r8_ie_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ie |=> $stable(ie));
endmodule

// File: rtl/tiv_pend.sv
module tiv_pend #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pulse,
  input  logic [NCH-1:0] ie,
  input  logic [NCH-1:0] chan_ie,
  input  logic [NCH-1:0] clr,
  output logic [NCH-1:0] pend
);
  logic [NCH-1:0] set_ev;
  assign set_ev = pulse & ie & chan_ie;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)         pend[i] <= 1'b0;
      else if (set_ev[i]) pend[i] <= 1'b1;
      else if (clr[i])    pend[i] <= 1'b0;
    end

    a_r2_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse[i] && ie[i] && chan_ie[i]) |=> pend[i]);
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && !clr[i]) |=> pend[i]);
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !(pulse[i] && ie[i] && chan_ie[i])) |=> !pend[i]);
  end
endmodule

// File: rtl/tiv_vec.sv
module tiv_vec import tiv_pkg::*; #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pend,
  input  logic [NCH-1:0] ie,
  input  logic           hw_en,
  input  logic [2:0]     top,
  input  logic           ack,
  output logic           irq_req,
  output logic [7:0]     vector
);
  logic [NCH-1:0] live;
  int unsigned    win;

  assign live    = pend & ie;
  assign irq_req = hw_en && (|live);

  always_comb begin
    win = 0;
    for (int i = NCH - 1; i >= 0; i--)
      if (live[i]) win = i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              vector <= '0;
    else if (ack && irq_req) vector <= tiv_vector(top, win);
  end

  a_r6_vector_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req) |=> (vector[0] == 1'b0 && vector[4:1] >= 4'd3 && vector[4:1] <= 4'd6));
  a_r9_vector_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && irq_req) |=> $stable(vector));
endmodule

// File: rtl/tmr_irq_vectorer.sv
module tmr_irq_vectorer #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [1:0]     cfg_sel,
  input  logic [7:0]     cfg_wdata,
  input  logic [NCH-1:0] tmo_pulse,
  input  logic [NCH-1:0] chan_ie,
  input  logic           irq_ack,
  output logic           irq_req,
  output logic [7:0]     irq_vector,
  output logic [NCH-1:0] pending,
  output logic [NCH-1:0] dma_req
);
  logic [2:0]     top;
  logic           hw_en;
  logic [NCH-1:0] ie, dmask, clr;

  tiv_cfg #(.NCH(NCH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
    .top(top), .hw_en(hw_en), .ie(ie), .dmask(dmask), .clr(clr)
  );

  tiv_pend #(.NCH(NCH)) u_pend (
    .clk(clk), .rst_n(rst_n), .pulse(tmo_pulse), .ie(ie), .chan_ie(chan_ie),
    .clr(clr), .pend(pending)
  );

  tiv_vec #(.NCH(NCH)) u_vec (
    .clk(clk), .rst_n(rst_n), .pend(pending), .ie(ie), .hw_en(hw_en), .top(top),
    .ack(irq_ack), .irq_req(irq_req), .vector(irq_vector)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) dma_req <= '0;
    else        dma_req <= tmo_pulse & dmask;
  end

  a_r5_off_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_en |-> !irq_req);
  a_r7_dma_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((dma_req & ~$past(tmo_pulse)) == '0));
endmodule

// File: tb/tb_tmr_irq_vectorer.sv
module tb_tmr_irq_vectorer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic [3:0] tmo_pulse = 4'd0;
  logic [3:0] chan_ie = 4'd0;
  logic       irq_ack = 1'b0;
  logic       irq_req;
  logic [7:0] irq_vector;
  logic [3:0] pending;
  logic [3:0] dma_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  tmr_irq_vectorer dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .tmo_pulse(tmo_pulse), .chan_ie(chan_ie), .irq_ack(irq_ack), .irq_req(irq_req),
    .irq_vector(irq_vector), .pending(pending), .dma_req(dma_req)
  );

  // behavioural reference model
  int m_top = 0, m_hw = 0, m_ie = 0, m_dm = 0, m_pend = 0, m_dma = 0, m_vec = 0;

  function automatic int m_req();
    return (m_hw != 0 && (m_pend & m_ie) != 0) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_top = 0; m_hw = 0; m_ie = 0; m_dm = 0; m_pend = 0; m_dma = 0; m_vec = 0;
    end else begin
      int np, c;
      if (irq_ack && m_req() != 0) begin
        c = 0;
        while (((m_pend & m_ie) >> c) % 2 == 0) c++;
        m_vec = m_top * 32 + 2 * (c + 3);
      end
      np = m_pend;
      for (int i = 0; i < 4; i++) begin
        if (cfg_wr && cfg_sel == 2 && cfg_wdata[i]) np = np & ~(1 << i);
        if (tmo_pulse[i] && chan_ie[i] && ((m_ie >> i) % 2 == 1)) np = np | (1 << i);
      end
      m_pend = np;
      m_dma  = tmo_pulse & m_dm;
      if (cfg_wr) begin
        case (cfg_sel)
          2'd0: begin m_top = cfg_wdata / 32; m_hw = cfg_wdata % 2; end
          2'd1: m_ie = cfg_wdata % 16;
          2'd3: m_dm = cfg_wdata % 16;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2/R3/R4 pending vs model", int'(pending), m_pend);
      chk("R5 irq_req vs model", int'(irq_req), m_req());
      chk("R6 irq_vector vs model", int'(irq_vector), m_vec);
      chk("R7 dma_req vs model", int'(dma_req), m_dma);
    end
  end

  task automatic cyc(input bit wr, input logic [1:0] sel, input logic [7:0] d,
                     input logic [3:0] p, input bit ack);
    @(negedge clk);
    cfg_wr = wr; cfg_sel = sel; cfg_wdata = d; tmo_pulse = p; irq_ack = ack;
    @(negedge clk);
    cfg_wr = 1'b0; tmo_pulse = 4'd0; irq_ack = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pending", int'(pending), 0);
    chk("R1 irq_req", int'(irq_req), 0);
    chk("R1 vector", int'(irq_vector), 0);
    chk("R1 dma_req", int'(dma_req), 0);

    chan_ie = 4'hF;
    // R8: vector cfg top=110, enable=1; then mask
    cyc(1, 2'd0, 8'b1100_0001, 4'd0, 0);
    cyc(1, 2'd1, 8'h0F, 4'd0, 0);
    // R2 latch channel 2
    cyc(0, 2'd0, 8'd0, 4'b0100, 0);
    chk("R2 latch ch2", int'(pending), 4'b0100);
    chk("R5 request up", int'(irq_req), 1);
    // R6 vector example
    cyc(0, 2'd0, 8'd0, 4'd0, 1);
    chk("R6 vector ch2 top 110", int'(irq_vector), 8'hCA);
    chk("R9 ack keeps pending", int'(pending), 4'b0100);
    // R3 repeated pulse no change
    cyc(0, 2'd0, 8'd0, 4'b0100, 0);
    chk("R3 sticky", int'(pending), 4'b0100);
    // multiple pending: lowest channel wins
    cyc(0, 2'd0, 8'd0, 4'b1001, 0);
    cyc(0, 2'd0, 8'd0, 4'd0, 1);
    chk("R6 lowest wins", int'(irq_vector), 8'hC6);
    // R4 partial clear
    cyc(1, 2'd2, 8'b0000_0001, 4'd0, 0);
    chk("R4 clear ch0 only", int'(pending), 4'b1100);
    cyc(0, 2'd0, 8'd0, 4'd0, 1);
    chk("R6 after clear", int'(irq_vector), 8'hCA);
    // R4 clear and pulse same cycle on ch3: set wins
    cyc(1, 2'd2, 8'b0000_1000, 4'b1000, 0);
    chk("R4 set beats clear", int'(pending), 4'b1100);
    // clear everything
    cyc(1, 2'd2, 8'h0F, 4'd0, 0);
    chk("R4 clear all", int'(pending), 0);
    chk("R5 request down", int'(irq_req), 0);
    // R9 ack without request keeps vector
    cyc(0, 2'd0, 8'd0, 4'd0, 1);
    chk("R9 vector held", int'(irq_vector), 8'hCA);
    // R2 control-word enable gates latching
    chan_ie = 4'b1110;
    cyc(0, 2'd0, 8'd0, 4'b0001, 0);
    chk("R2 chan_ie gate", int'(pending), 0);
    chan_ie = 4'hF;
    // R2 mask gates latching, R8 mask write
    cyc(1, 2'd1, 8'b0000_0010, 4'd0, 0);
    cyc(0, 2'd0, 8'd0, 4'b0001, 0);
    chk("R2 mask gate", int'(pending), 0);
    cyc(0, 2'd0, 8'd0, 4'b0010, 0);
    chk("R2 ch1 latch", int'(pending), 4'b0010);
    // R5 vectoring off drops request; R8 new top bits
    cyc(1, 2'd0, 8'b0010_0000, 4'd0, 0);
    chk("R5 off no request", int'(irq_req), 0);
    cyc(1, 2'd0, 8'b0010_0001, 4'd0, 0);
    chk("R5 back on", int'(irq_req), 1);
    cyc(0, 2'd0, 8'd0, 4'd0, 1);
    chk("R6 ch1 top 001", int'(irq_vector), 8'h28);
    // R5 pending but mask cleared
    cyc(1, 2'd1, 8'd0, 4'd0, 0);
    chk("R5 masked pending", int'(irq_req), 0);
    chk("R8 mask write kept pending", int'(pending), 4'b0010);
    // R7 DMA triggers independent of interrupt settings
    cyc(1, 2'd3, 8'b0000_0101, 4'd0, 0);
    @(negedge clk);
    tmo_pulse = 4'hF;
    @(negedge clk);
    tmo_pulse = 4'd0;
    chk("R7 dma mask", int'(dma_req), 4'b0101);
    @(negedge clk);
    chk("R7 dma one cycle", int'(dma_req), 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule